// File: doc/BRIEF.md
# Up/Down BCD Decade Counter with Ripple Carry

This block is a single decimal digit counter that steps through the codes 0 to 9 in either direction on the rising clock edge. Counting is gated by an active-low enable and steered by a direction input. An active-low load input forces the digit to a value on the preset inputs at once, without waiting for a clock edge, and this load wins over counting.

Two outputs mark the end of a decade. The terminal flag is decoded from the digit and the direction. The active-low ripple output is a clock-phase-gated copy of that flag. Feeding one digit's ripple output into the next digit's clock builds a multi-digit counter. Codes 10 to 15 can only enter the state through a preset, and the next count step leaves them for a legal code.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `load_n` is 0, `q` equals `preset` at once and follows it without a clock edge, and clock edges do not count.
- R2: With `load_n` at 1 and `cnt_en_n` at 1, `q` does not change across rising clock edges.
- R3: With `cnt_en_n` at 0 and `dir_down` at 0, each rising edge takes `q` from n to n+1 for n in 0..8, and from 9 to 0.
- R4: With `cnt_en_n` at 0 and `dir_down` at 1, each rising edge takes `q` from n to n-1 for n in 1..9, and from 0 to 9.
- R5: Counting up from any code 10 to 15 gives 0.
- R6: Counting down from any code 10 to 15 gives 9.
- R7: `tc` is 1 exactly when `q` is 9 with `dir_down` at 0, or `q` is 0 with `dir_down` at 1. It is 0 for codes 10 to 15, and it follows a change of `dir_down` without a clock edge.
- R8: `rc_n` is 0 only while `cnt_en_n` is 0, `tc` is 1 and `clk` is 0. It is 1 whenever `clk` is 1.
- R9: The first rising edge after `load_n` returns to 1 counts from the loaded value.
- R10: Two stages, with the second clocked by the first's `rc_n` and its enable tied to 0, count as a two-digit decimal value modulo 100, both up and down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| load_n | input | 1 | Asynchronous preset, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| preset | input | 4 | Value forced in during a load |
| q | output | 4 | Current digit |
| tc | output | 1 | Terminal flag, active high |
| rc_n | output | 1 | Ripple clock for the next stage, active low |

## Verification
The digit is run through full decades in both directions, so the n+1 and n-1 steps and the two wrap points are each seen separately. Presets of all six illegal codes, each followed by one step in each direction, separate recovery from the normal wrap logic. Flipping the direction while sitting at 9 or 0 shows that the terminal flag follows direction without a clock edge. Enable-high runs at a terminal value separate the ripple gating from the flag itself. A two-stage chain counted past 99 and then back down past 00 checks that the ripple output gives exactly one clock per decade to the next digit.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // one step upward; codes at or above the top fall to zero
  function automatic digit_t step_up(digit_t d);
    if (d >= DIGIT_MAX) return '0;
    return d + 1'b1;
  endfunction

  // one step downward; zero and illegal codes land on the top value
  function automatic digit_t step_down(digit_t d);
    if (d == '0 || d > DIGIT_MAX) return DIGIT_MAX;
    return d - 1'b1;
  endfunction

  function automatic logic at_terminal(digit_t d, logic down);
    return down ? (d == '0) : (d == DIGIT_MAX);
  endfunction
endpackage

// File: rtl/bcd_next_state.sv
module bcd_next_state
  import bcd_cnt_pkg::*;
(
  input  digit_t cur,
  input  logic   dir_down,
  output digit_t nxt
);
  digit_t up_val;
  digit_t dn_val;

  always_comb begin
    up_val = step_up(cur);
    dn_val = step_down(cur);
    nxt    = dir_down ? dn_val : up_val;
  end
endmodule

// File: rtl/bcd_state_reg.sv
module bcd_state_reg
  import bcd_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   load_n,
  input  logic   cnt_en_n,
  input  digit_t preset,
  input  digit_t nxt,
  output digit_t state
);
  // preset enters through the asynchronous set/clear path
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n)        state <= preset;
    else if (!cnt_en_n) state <= nxt;
  end

  AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!load_n)
    cnt_en_n |=> $stable(state)); // R2
endmodule

// File: rtl/bcd_carry_out.sv
module bcd_carry_out
  import bcd_cnt_pkg::*;
(
  input  logic   clk,
  input  logic   load_n,
  input  logic   cnt_en_n,
  input  logic   dir_down,
  input  digit_t digit,
  output logic   tc,
  output logic   rc_n
);
  logic clk_low_window;

  always_comb begin
    tc             = at_terminal(digit, dir_down);
    clk_low_window = !clk;
    rc_n           = !(!cnt_en_n && tc && clk_low_window);
  end

  AST_RC_HIGH_IN_HIGH_PHASE: assert property (@(negedge clk) disable iff (!load_n)
    rc_n); // R8
  AST_RC_NEEDS_ENABLE: assert property (@(negedge clk) disable iff (!load_n)
    cnt_en_n |-> rc_n); // R8
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_cnt_pkg::*;
(
  input  logic       clk,
  input  logic       load_n,
  input  logic       cnt_en_n,
  input  logic       dir_down,
  input  logic [3:0] preset,
  output logic [3:0] q,
  output logic       tc,
  output logic       rc_n
);
  digit_t state;
  digit_t nxt;
  logic   count_up_evt;
  logic   count_dn_evt;
  logic   illegal_code;

  bcd_next_state u_next (
    .cur      (state),
    .dir_down (dir_down),
    .nxt      (nxt)
  );

  bcd_state_reg u_reg (
    .clk      (clk),
    .load_n   (load_n),
    .cnt_en_n (cnt_en_n),
    .preset   (preset),
    .nxt      (nxt),
    .state    (state)
  );

  // the load path is transparent while held low
  assign q = load_n ? state : preset;

  bcd_carry_out u_carry (
    .clk      (clk),
    .load_n   (load_n),
    .cnt_en_n (cnt_en_n),
    .dir_down (dir_down),
    .digit    (q),
    .tc       (tc),
    .rc_n     (rc_n)
  );

  assign count_up_evt = !cnt_en_n && !dir_down;
  assign count_dn_evt = !cnt_en_n && dir_down;
  assign illegal_code = state > DIGIT_MAX;

  AST_UP_STEP: assert property (@(posedge clk) disable iff (!load_n)
    (count_up_evt && state < 4'd9) |=> state == $past(state) + 4'd1); // R3
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!load_n)
    (count_up_evt && state == 4'd9) |=> state == 4'd0); // R3
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!load_n)
    (count_dn_evt && state != 4'd0 && !illegal_code) |=> state == $past(state) - 4'd1); // R4
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!load_n)
    (count_dn_evt && state == 4'd0) |=> state == 4'd9); // R4
  AST_ILLEGAL_UP: assert property (@(posedge clk) disable iff (!load_n)
    (count_up_evt && illegal_code) |=> state == 4'd0); // R5
  AST_ILLEGAL_DOWN: assert property (@(posedge clk) disable iff (!load_n)
    (count_dn_evt && illegal_code) |=> state == 4'd9); // R6
  AST_TC_ONLY_AT_ENDS: assert property (@(posedge clk) disable iff (!load_n)
    tc |-> (q == 4'd0 || q == 4'd9)); // R7
  AST_TC_LOW_ILLEGAL: assert property (@(posedge clk) disable iff (!load_n)
    illegal_code |-> !tc); // R7
endmodule

// File: tb/bcd_updown_counter_test.sv
module bcd_updown_counter_test;
  logic       clk = 1'b0;
  logic       load_n, cnt_en_n, dir_down;
  logic [3:0] preset;
  logic [3:0] q;
  logic       tc, rc_n;

  logic       c_load_n;
  logic       tie_low = 1'b0;
  logic [3:0] tie_zero = 4'd0;
  logic [3:0] c_q0, c_q1;
  logic       c_tc0, c_tc1, c_rc0, c_rc1;

  int n_chk = 0;
  int n_fail = 0;
  int ref_q;
  int casc_ref;
  bit finished = 0;

  always #5 clk = ~clk;

  bcd_updown_counter uut (
    .clk(clk), .load_n(load_n), .cnt_en_n(cnt_en_n), .dir_down(dir_down),
    .preset(preset), .q(q), .tc(tc), .rc_n(rc_n));

  bcd_updown_counter stage_lo (
    .clk(clk), .load_n(c_load_n), .cnt_en_n(tie_low), .dir_down(dir_down),
    .preset(tie_zero), .q(c_q0), .tc(c_tc0), .rc_n(c_rc0));

  bcd_updown_counter stage_hi (
    .clk(c_rc0), .load_n(c_load_n), .cnt_en_n(tie_low), .dir_down(dir_down),
    .preset(tie_zero), .q(c_q1), .tc(c_tc1), .rc_n(c_rc1));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic want_tc(int v, logic down);
    if (down) return v == 0;
    return v == 9;
  endfunction

  // called in the low clock phase; runs through one rising edge
  task automatic tick(string tag);
    #1;
    chk("R7", {7'd0, tc}, {7'd0, want_tc(ref_q, dir_down)});
    chk("R8", {7'd0, rc_n}, {7'd0, !(!cnt_en_n && want_tc(ref_q, dir_down))});
    @(posedge clk);
    if (load_n && !cnt_en_n) begin
      if (!dir_down) ref_q = (ref_q < 9) ? ref_q + 1 : 0;
      else           ref_q = (ref_q >= 1 && ref_q <= 9) ? ref_q - 1 : 9;
    end
    #2;
    chk(tag, {4'd0, q}, ref_q[7:0]);
    chk("R8", {7'd0, rc_n}, 8'd1);
    @(negedge clk);
  endtask

  task automatic load_val(int v);
    preset = 4'd5;
    load_n = 1'b0;
    #1 chk("R1", {4'd0, q}, 8'd5);
    preset = v[3:0];
    #1 chk("R1", {4'd0, q}, v[7:0]);
    @(posedge clk);
    #2 chk("R1", {4'd0, q}, v[7:0]);
    @(negedge clk);
    load_n = 1'b1;
    ref_q = v;
    #1 chk("R9", {4'd0, q}, v[7:0]);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    load_n = 1'b0; cnt_en_n = 1'b1; dir_down = 1'b0; preset = 4'd0; c_load_n = 1'b0;
    ref_q = 0;
    @(negedge clk); @(negedge clk);
    chk("R1", {4'd0, q}, 8'd0);

    // R9 then R3: full upward decade including 9 -> 0
    load_val(0);
    cnt_en_n = 1'b0;
    tick("R9");
    for (int i = 0; i < 11; i++) tick("R3");

    // R2: enable high holds
    cnt_en_n = 1'b1;
    for (int i = 0; i < 3; i++) tick("R2");

    // R4: downward decade including 0 -> 9
    cnt_en_n = 1'b0; dir_down = 1'b1;
    for (int i = 0; i < 12; i++) tick("R4");

    // R7: direction flips at the ends
    cnt_en_n = 1'b1;
    load_val(9);
    dir_down = 1'b0; #1 chk("R7", {7'd0, tc}, 8'd1);
    dir_down = 1'b1; #1 chk("R7", {7'd0, tc}, 8'd0);
    dir_down = 1'b0; #1 chk("R7", {7'd0, tc}, 8'd1);
    tick("R2");
    cnt_en_n = 1'b0;
    tick("R3");
    load_val(0);
    dir_down = 1'b1; #1 chk("R7", {7'd0, tc}, 8'd1);
    dir_down = 1'b0; #1 chk("R7", {7'd0, tc}, 8'd0);
    dir_down = 1'b1;
    tick("R4");

    // R5 and R6: recovery from illegal codes
    for (int v = 10; v < 16; v++) begin
      load_val(v);
      dir_down = 1'b0;
      #1 chk("R7", {7'd0, tc}, 8'd0);
      tick("R5");
      load_val(v);
      dir_down = 1'b1;
      #1 chk("R7", {7'd0, tc}, 8'd0);
      tick("R6");
    end

    // R8: terminal value with enable high keeps rc_n high
    cnt_en_n = 1'b1; dir_down = 1'b0;
    load_val(9);
    tick("R8");

    // R10: two-stage chain
    dir_down = 1'b0;
    @(negedge clk);
    c_load_n = 1'b1;
    casc_ref = 0;
    for (int i = 0; i < 120; i++) begin
      @(posedge clk);
      casc_ref = (casc_ref + 1) % 100;
      #2 chk("R10", c_q1 * 8'd10 + {4'd0, c_q0}, casc_ref[7:0]);
    end
    dir_down = 1'b1; // changed in the high phase, when rc_n is held high
    for (int i = 0; i < 130; i++) begin
      @(posedge clk);
      casc_ref = (casc_ref + 99) % 100;
      #2 chk("R10", c_q1 * 8'd10 + {4'd0, c_q0}, casc_ref[7:0]);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule